// File: doc/BRIEF.md
# Daisy-Chained Serial Configuration Loader

This block fills a device's setup register from a single serial bit stream. While the enable coming from the previous stage is asserted (low), each rising clock edge moves one bit from the serial input into the register. Once the register holds its full length of bits, the block stops shifting, drives its chain-enable output low and from then on routes its serial input straight through to its serial output. The next device in a chain takes that output as its serial input and the chain-enable output as its enable, so it starts loading only when this one is complete.

A separate active-high "programming complete" qualifier lets other logic (for example, write-queue selection) stay blocked until loading has finished. The register contents are exposed as a parallel word for the decoding logic that sits beside the block. A synchronous active-high reset empties the loader and returns it to the loading phase.

Top module: `cfg_chain_loader`

## Requirements
- R1: While reset is applied and in the cycle after it, `chain_en_n_o` is 1, `prog_done_o` is 0, `cfg_word_o` is all zeros and `ser_out_o` is 0.
- R2: On a rising clock edge where `chain_en_n_i` is 0 and the register is not yet full, the word shifts up by one and `ser_in_i` enters bit 0, so the first bit received ends in bit CFG_BITS-1.
- R3: On an edge where `chain_en_n_i` is 1, the word and the loaded-bit count keep their values.
- R4: `chain_en_n_o` goes to 0 right after the edge that captures the CFG_BITS-th enabled bit, not earlier, and stays 0 until reset.
- R5: Once full, `cfg_word_o` does not change whatever `ser_in_i` and `chain_en_n_i` do.
- R6: While not full, `ser_out_o` is 0; once full, `ser_out_o` equals `ser_in_i` in the same cycle, with no register on the path.
- R7: `prog_done_o` is always the complement of `chain_en_n_o`.
- R8: When two loaders are chained (output of one to input of the next, `chain_en_n_o` to `chain_en_n_i`), the second receives no bits until the first is full, and then loads the bits that follow in order.
- R9: Reset applied part way through loading empties the register and restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ser_in_i | input | 1 | Serial configuration data in |
| chain_en_n_i | input | 1 | Load enable from previous stage, active low |
| ser_out_o | output | 1 | Serial data to the next stage |
| chain_en_n_o | output | 1 | Enable to next stage, low once this register is full |
| prog_done_o | output | 1 | Programming complete qualifier, active high |
| cfg_word_o | output | CFG_BITS | Loaded setup register contents |

## Verification
The bench chains a 16-bit and an 8-bit loader and goes after the full/empty boundary: a counter off by one would drop the enable one bit early or late, leaving a stray bit in the wrong device and shifting the downstream pattern by one position. Gaps in the upstream enable test that a pause does not shift in junk, and bits sent after both devices are full test that a register which keeps shifting corrupts its pattern. A reset part way through loading catches a counter that is not cleared, which would end loading early on the second attempt, and the same-cycle pass-through check catches a pass path that was registered instead of routed directly.

// File: rtl/cfg_chain_pkg.sv
package cfg_chain_pkg;

    typedef enum logic {
        PH_LOAD = 1'b0,
        PH_PASS = 1'b1
    } cfg_phase_e;

    function automatic int cnt_width(input int nbits);
        return (nbits < 2) ? 1 : $clog2(nbits + 1);
    endfunction

endpackage

// File: rtl/cfg_bit_counter.sv
module cfg_bit_counter
    import cfg_chain_pkg::*;
#(
    parameter int CFG_BITS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en_active_i,
    output logic       shift_o,
    output cfg_phase_e phase_o
);
    localparam int CW = cnt_width(CFG_BITS);
    localparam logic [CW-1:0] LAST = CW'(CFG_BITS - 1);

    logic [CW-1:0] cnt_q;
    cfg_phase_e    phase_q;

    assign shift_o = en_active_i && (phase_q == PH_LOAD);
    assign phase_o = phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            phase_q <= PH_LOAD;
        end else if (shift_o) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
                phase_q <= PH_PASS;
            end
        end
    end

    // R4: once passing, stays passing until reset
    a_r4_pass_sticky: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_PASS) |=> (phase_q == PH_PASS));

    // R3: no enabled shift means the count holds
    a_r3_count_hold: assert property (@(posedge clk) disable iff (rst)
        (!en_active_i) |=> $stable(cnt_q));

    // R4: count never exceeds the register length
    a_r4_no_overrun: assert property (@(posedge clk) disable iff (rst)
        (cnt_q <= CW'(CFG_BITS)));

endmodule

// File: rtl/cfg_shift_reg.sv
module cfg_shift_reg #(
    parameter int CFG_BITS = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                shift_i,
    input  logic                bit_i,
    output logic [CFG_BITS-1:0] word_o
);
    logic [CFG_BITS-1:0] sr_q;

    generate
        if (CFG_BITS == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst)          sr_q <= '0;
                else if (shift_i) sr_q <= bit_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst)          sr_q <= '0;
                else if (shift_i) sr_q <= {sr_q[CFG_BITS-2:0], bit_i};
            end
        end
    endgenerate

    assign word_o = sr_q;

    // R5 / R3: without a shift command the contents hold
    a_r5_frozen: assert property (@(posedge clk) disable iff (rst)
        (!shift_i) |=> $stable(sr_q));

endmodule

// File: rtl/cfg_pass_mux.sv
module cfg_pass_mux
    import cfg_chain_pkg::*;
(
    input  cfg_phase_e phase_i,
    input  logic       ser_in_i,
    output logic       ser_out_o
);
    always_comb begin
        unique case (phase_i)
            PH_PASS: ser_out_o = ser_in_i;
            default: ser_out_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/cfg_chain_loader.sv
module cfg_chain_loader
    import cfg_chain_pkg::*;
#(
    parameter int CFG_BITS = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ser_in_i,
    input  logic                chain_en_n_i,
    output logic                ser_out_o,
    output logic                chain_en_n_o,
    output logic                prog_done_o,
    output logic [CFG_BITS-1:0] cfg_word_o
);
    cfg_phase_e phase;
    logic       shift;

    cfg_bit_counter #(.CFG_BITS(CFG_BITS)) u_counter (
        .clk         (clk),
        .rst         (rst),
        .en_active_i (!chain_en_n_i),
        .shift_o     (shift),
        .phase_o     (phase)
    );

    cfg_shift_reg #(.CFG_BITS(CFG_BITS)) u_shreg (
        .clk     (clk),
        .rst     (rst),
        .shift_i (shift),
        .bit_i   (ser_in_i),
        .word_o  (cfg_word_o)
    );

    cfg_pass_mux u_mux (
        .phase_i   (phase),
        .ser_in_i  (ser_in_i),
        .ser_out_o (ser_out_o)
    );

    assign prog_done_o  = (phase == PH_PASS);
    assign chain_en_n_o = (phase != PH_PASS);

    // R2 / R4: completion only follows an enabled edge
    a_r4_done_after_enabled: assert property (@(posedge clk) disable iff (rst)
        $rose(prog_done_o) |-> $past(!chain_en_n_i));

    // R7: qualifier and chain enable are complementary
    a_r7_complement: assert property (@(posedge clk) disable iff (rst)
        (prog_done_o != chain_en_n_o));

    // R6: once full, the serial input reaches the output in the same cycle
    a_r6_pass_through: assert property (@(posedge clk) disable iff (rst)
        prog_done_o |-> (ser_out_o == ser_in_i));

    // R6: while loading, the output is held low
    a_r6_quiet_while_loading: assert property (@(posedge clk) disable iff (rst)
        chain_en_n_o |-> (ser_out_o == 1'b0));

    // R9: reset brings the loader back to loading
    a_r9_reset_restarts: assert property (@(posedge clk)
        rst |=> (chain_en_n_o && cfg_word_o == '0));

endmodule

// File: tb/cfg_chain_loader_bench.sv
module cfg_chain_loader_bench;
    localparam int NA = 16;
    localparam int NB = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_in = 1'b0;
    logic en_n = 1'b1;

    logic          so_a, eno_a, pd_a;
    logic [NA-1:0] word_a;
    logic          so_b, eno_b, pd_b;
    logic [NB-1:0] word_b;

    int vectors = 0;
    int errors  = 0;

    logic [NA-1:0] exp_a = '0;
    logic [NB-1:0] exp_b = '0;
    int cnt_a = 0;
    int cnt_b = 0;

    always #10 clk = ~clk;

    cfg_chain_loader #(.CFG_BITS(NA)) u_cfg_chain_loader (
        .clk(clk), .rst(rst), .ser_in_i(ser_in), .chain_en_n_i(en_n),
        .ser_out_o(so_a), .chain_en_n_o(eno_a), .prog_done_o(pd_a),
        .cfg_word_o(word_a)
    );

    cfg_chain_loader #(.CFG_BITS(NB)) u_down (
        .clk(clk), .rst(rst), .ser_in_i(so_a), .chain_en_n_i(eno_a),
        .ser_out_o(so_b), .chain_en_n_o(eno_b), .prog_done_o(pd_b),
        .cfg_word_o(word_b)
    );

    initial begin
        #3_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_out(input int cnt, input int n, input logic din);
        return (cnt == n) ? din : 1'b0;
    endfunction

    task automatic check_state();
        chk(32'(word_a), 32'(exp_a), "R2/R5 upstream word");
        chk(32'(word_b), 32'(exp_b), "R8 downstream word");
        chk(32'(eno_a), 32'(cnt_a != NA), "R4 upstream chain enable");
        chk(32'(eno_b), 32'(cnt_b != NB), "R4 downstream chain enable");
        chk(32'(pd_a), 32'(!eno_a), "R7 upstream qualifier");
        chk(32'(pd_b), 32'(!eno_b), "R7 downstream qualifier");
    endtask

    task automatic step(input logic b, input logic e_n, input logic r);
        logic a_out;
        @(negedge clk);
        ser_in = b; en_n = e_n; rst = r;
        #1;
        a_out = exp_out(cnt_a, NA, b);
        chk(32'(so_a), 32'(a_out), "R6 upstream serial out");
        chk(32'(so_b), 32'(exp_out(cnt_b, NB, a_out)), "R6 downstream serial out");
        if (r) begin
            exp_a = '0; exp_b = '0; cnt_a = 0; cnt_b = 0;
        end else begin
            if (cnt_a == NA && cnt_b < NB) begin
                exp_b = {exp_b[NB-2:0], a_out};
                cnt_b++;
            end
            if (!e_n && cnt_a < NA) begin
                exp_a = {exp_a[NA-2:0], b};
                cnt_a++;
            end
        end
        @(posedge clk);
        #2;
        check_state();
    endtask

    initial begin
        void'($urandom(32'd1234));
        // R1: reset state
        step(1'b1, 1'b0, 1'b1);
        chk(32'(word_a), 0, "R1 word cleared");
        chk(32'(eno_a), 1, "R1 chain enable high");
        chk(32'(pd_a), 0, "R1 qualifier low");
        chk(32'(so_a), 0, "R1 serial out low");

        // R3: enable inactive, nothing loads
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b0);
        chk(32'(word_a), 0, "R3 idle enable holds word");

        // R9: partial load then reset
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b1);
        chk(32'(word_a), 0, "R9 reset mid-load clears word");
        chk(32'(eno_a), 1, "R9 reset mid-load re-enters loading");

        // R2/R3/R4/R8: random bits with random gaps until both full
        for (int i = 0; i < 400 && !(cnt_a == NA && cnt_b == NB); i++) begin
            step(1'($urandom), ($urandom % 4) == 0, 1'b0);
        end
        chk(32'(pd_b), 1, "R8 downstream completes after upstream");

        // R5/R6: extra traffic after both full
        for (int i = 0; i < 20; i++) step(1'($urandom), 1'($urandom), 1'b0);

        // R2/R4: directed exact-length pattern after reset
        step(1'b0, 1'b1, 1'b1);
        for (int i = 0; i < NA; i++) begin
            chk(32'(eno_a), 1, "R4 not done before last bit");
            step(1'(i % 3 == 0), 1'b0, 1'b0);
        end
        chk(32'(word_a), 32'(16'b1001001001001001), "R2 first bit at top");
        for (int i = 0; i < NB; i++) step(1'(i < 4), 1'b0, 1'b0);
        chk(32'(word_b), 32'(8'hF0), "R8 downstream pattern");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule